// File: doc/BRIEF.md
# Legacy Interrupt Routing Matrix

This block steers interrupt requests from legacy peripherals (two serial ports, a parallel port, a floppy controller, the first IDE channel and four shared PCI interrupt wires) onto eight numbered inputs of a priority interrupt controller. Software programs the steering through a 32-bit configuration port. The port is addressed by dword byte offset and always written one whole dword at a time. Each source owns a 4-bit destination field. A field of zero leaves the source unrouted, and fields name lines 1 to 7 in practice.

Some sources also have a function-enable bit. A disabled function's request is dropped before routing. Requests that land on the same line are ORed. A per-line trigger bit then chooses how the merged request leaves the block. A level line passes the merged request through a register. An edge line emits a single-cycle pulse when the merged request rises.

Top module: `sirq_route_matrix`

## Requirements
- R1: After reset every enable, trigger and destination field is zero, `irq_out` is all zero, every register reads zero, and no source reaches any line.
- R2: Offset 0x68 lane 1 (bits 15:8) holds the serial destinations: serial port 1 in bits 11:8 and serial port 2 in bits 15:12. Writing 0x43 there routes port 1 to line 3 and port 2 to line 4.
- R3: Offset 0x68 lane 2 holds the parallel destination in bits 19:16 and the floppy destination in bits 23:20. Lane 3 holds IDE channel 1 in bits 27:24. Bits 31:28 are reserved: they are not stored and always read zero.
- R4: Offset 0x6C lane 0 holds PCI INTA in bits 3:0 and INTB in bits 7:4. Lane 1 holds INTC in bits 11:8 and INTD (the USB source) in bits 15:12. Writing 0x00001000 routes INTD to line 1.
- R5: A destination field of 0 leaves its source unrouted. Field values 8 to 15 route nowhere. Line 0 is never asserted.
- R6: Offset 0x58 lane 2 (bits 23:16) is the function-enable byte. Bit 16 enables floppy, bit 17 serial 1, bit 18 IDE 1, bit 19 serial 2 and bit 21 parallel. Bits 20, 22 and 23 are stored but have no routing effect. A disabled source has no effect on any line. The PCI sources have no enable bit and are always routed.
- R7: When several enabled sources share a line, the line's request is the OR of their requests.
- R8: Offset 0x64 lane 3 (bits 31:24) is the trigger byte. When bit 24+n is 1, line n is level type, and `irq_out[n]` equals the merged request of the previous cycle.
- R9: When the trigger bit is 0, line n is edge type. `irq_out[n]` is high for exactly one cycle, in the cycle after the merged request goes from low to high. A request held high gives one pulse.
- R10: Reads are combinational on `cfg_addr` and return the stored fields at the positions above. Lanes that hold no field, and every other offset, read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for a whole dword |
| cfg_addr | input | 8 | Dword byte offset |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr` |
| src_req | input | 9 | Source requests: 0 serial 1, 1 serial 2, 2 parallel, 3 floppy, 4 IDE 1, 5 INTA, 6 INTB, 7 INTC, 8 INTD |
| irq_out | output | 8 | Registered request lines to the priority controller |

## Verification
The bound checker watches the line shaping on every cycle:
- an edge-type line never stays high two cycles running;
- a level-type line tracks the merged request one cycle later;
- no output rises without a merged request behind it;
- the reserved IDE nibble always reads zero;
- reset clears the outputs.

Which source reaches which line, enable gating, the packing of fields into byte lanes, and sharing a line between sources can only be shown by the bench. It programs real layouts, drives each source alone and in combination, and compares against a model built from the register description.

// File: rtl/sirq_route_pkg.sv
package sirq_route_pkg;

    localparam int LINES  = 8;
    localparam int FLD_W  = 4;
    localparam int SRC_N  = 9;
    localparam int DW     = 32;
    localparam int AW     = 8;
    localparam int LINE_W = $clog2(LINES);

    // Register offsets (software contract)
    localparam logic [AW-1:0] OFS_ENABLE = 8'h58;
    localparam logic [AW-1:0] OFS_TRIG   = 8'h64;
    localparam logic [AW-1:0] OFS_MAP_A  = 8'h68;
    localparam logic [AW-1:0] OFS_MAP_B  = 8'h6C;

    // Source indices on src_req
    localparam int SRC_SER1 = 0;
    localparam int SRC_SER2 = 1;
    localparam int SRC_PAR  = 2;
    localparam int SRC_FDC  = 3;
    localparam int SRC_IDE1 = 4;
    localparam int SRC_INTA = 5;
    localparam int SRC_INTB = 6;
    localparam int SRC_INTC = 7;
    localparam int SRC_INTD = 8;

    // Bit positions inside the enable byte
    localparam int EN_FDC  = 0;
    localparam int EN_SER1 = 1;
    localparam int EN_IDE1 = 2;
    localparam int EN_SER2 = 3;
    localparam int EN_PAR  = 5;

    typedef logic [FLD_W-1:0] dest_t;

    typedef struct packed {
        logic [7:0]             enables;
        logic [LINES-1:0]       level;
        dest_t [SRC_N-1:0]      dest;
    } route_cfg_t;

    // Gate a source by its function-enable bit; PCI wires are always on.
    function automatic logic src_enabled(input logic [7:0] en, input int s);
        logic r;
        case (s)
            SRC_FDC:  r = en[EN_FDC];
            SRC_SER1: r = en[EN_SER1];
            SRC_IDE1: r = en[EN_IDE1];
            SRC_SER2: r = en[EN_SER2];
            SRC_PAR:  r = en[EN_PAR];
            default:  r = 1'b1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sirq_cfg_regs.sv
module sirq_cfg_regs
    import sirq_route_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output route_cfg_t    cfg
);

    route_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (we) begin
            case (addr)
                OFS_ENABLE: cfg_q.enables <= wdata[23:16];
                OFS_TRIG:   cfg_q.level   <= wdata[31:24];
                OFS_MAP_A: begin
                    cfg_q.dest[SRC_SER1] <= wdata[11:8];
                    cfg_q.dest[SRC_SER2] <= wdata[15:12];
                    cfg_q.dest[SRC_PAR]  <= wdata[19:16];
                    cfg_q.dest[SRC_FDC]  <= wdata[23:20];
                    cfg_q.dest[SRC_IDE1] <= wdata[27:24];
                end
                OFS_MAP_B: begin
                    cfg_q.dest[SRC_INTA] <= wdata[3:0];
                    cfg_q.dest[SRC_INTB] <= wdata[7:4];
                    cfg_q.dest[SRC_INTC] <= wdata[11:8];
                    cfg_q.dest[SRC_INTD] <= wdata[15:12];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            OFS_ENABLE: rdata[23:16] = cfg_q.enables;
            OFS_TRIG:   rdata[31:24] = cfg_q.level;
            OFS_MAP_A: begin
                rdata[11:8]  = cfg_q.dest[SRC_SER1];
                rdata[15:12] = cfg_q.dest[SRC_SER2];
                rdata[19:16] = cfg_q.dest[SRC_PAR];
                rdata[23:20] = cfg_q.dest[SRC_FDC];
                rdata[27:24] = cfg_q.dest[SRC_IDE1];
            end
            OFS_MAP_B: begin
                rdata[3:0]   = cfg_q.dest[SRC_INTA];
                rdata[7:4]   = cfg_q.dest[SRC_INTB];
                rdata[11:8]  = cfg_q.dest[SRC_INTC];
                rdata[15:12] = cfg_q.dest[SRC_INTD];
            end
            default: ;
        endcase
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/sirq_src_map.sv
module sirq_src_map
    import sirq_route_pkg::*;
(
    input  route_cfg_t       cfg,
    input  logic [SRC_N-1:0] src_req,
    output logic [LINES-1:0] merged
);

    logic [SRC_N-1:0] gated;

    for (genvar s = 0; s < SRC_N; s++) begin : g_gate
        assign gated[s] = src_req[s] & src_enabled(cfg.enables, s);
    end

    for (genvar l = 0; l < LINES; l++) begin : g_line
        if (l == 0) begin : g_unrouted
            // Field value 0 means "no line", so line 0 collects nothing.
            assign merged[l] = 1'b0;
        end else begin : g_or
            logic [SRC_N-1:0] hits;
            for (genvar s = 0; s < SRC_N; s++) begin : g_hit
                assign hits[s] = gated[s] && (cfg.dest[s] == FLD_W'(l));
            end
            assign merged[l] = |hits;
        end
    end

endmodule

// File: rtl/sirq_line_shaper.sv
module sirq_line_shaper (
    input  logic clk,
    input  logic rst,
    input  logic level_mode,
    input  logic req,
    output logic irq
);

    logic req_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_prev <= 1'b0;
            irq      <= 1'b0;
        end else begin
            req_prev <= req;
            irq      <= level_mode ? req : (req & ~req_prev);
        end
    end

endmodule

// File: rtl/sirq_route_matrix.sv
module sirq_route_matrix
    import sirq_route_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [AW-1:0]    cfg_addr,
    input  logic [DW-1:0]    cfg_wdata,
    output logic [DW-1:0]    cfg_rdata,
    input  logic [SRC_N-1:0] src_req,
    output logic [LINES-1:0] irq_out
);

    route_cfg_t       route_cfg;
    logic [LINES-1:0] merged_req;

    sirq_cfg_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .cfg   (route_cfg)
    );

    sirq_src_map u_map (
        .cfg     (route_cfg),
        .src_req (src_req),
        .merged  (merged_req)
    );

    for (genvar l = 0; l < LINES; l++) begin : g_shape
        sirq_line_shaper u_shaper (
            .clk        (clk),
            .rst        (rst),
            .level_mode (route_cfg.level[l]),
            .req        (merged_req[l]),
            .irq        (irq_out[l])
        );
    end

endmodule

// File: rtl/sirq_route_checks.sv
module sirq_route_checks
    import sirq_route_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [AW-1:0]    cfg_addr,
    input logic [DW-1:0]    cfg_rdata,
    input logic [LINES-1:0] level,
    input logic [LINES-1:0] merged,
    input logic [LINES-1:0] irq_out
);

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (irq_out == '0));

    p_ide_rsvd_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (cfg_addr == OFS_MAP_A) |-> (cfg_rdata[31:28] == 4'h0));

    for (genvar i = 0; i < LINES; i++) begin : g_line
        p_out_needs_req_r7: assert property (@(posedge clk) disable iff (rst)
            irq_out[i] |-> $past(merged[i]));

        p_level_follow_r8: assert property (@(posedge clk) disable iff (rst)
            $past(level[i]) |-> (irq_out[i] == $past(merged[i])));

        p_edge_single_r9: assert property (@(posedge clk) disable iff (rst)
            (irq_out[i] && !$past(level[i])) |=> !(irq_out[i] && !$past(level[i])));
    end

endmodule

bind sirq_route_matrix sirq_route_checks u_checks (
    .clk       (clk),
    .rst       (rst),
    .cfg_addr  (cfg_addr),
    .cfg_rdata (cfg_rdata),
    .level     (route_cfg.level),
    .merged    (merged_req),
    .irq_out   (irq_out)
);

// File: tb/sirq_route_matrix_bench.sv
module sirq_route_matrix_bench;
    import sirq_route_pkg::*;

    logic             clk = 1'b0;
    logic             rst;
    logic             cfg_we;
    logic [AW-1:0]    cfg_addr;
    logic [DW-1:0]    cfg_wdata;
    logic [DW-1:0]    cfg_rdata;
    logic [SRC_N-1:0] src_req;
    logic [LINES-1:0] irq_out;

    always #5 clk = ~clk;

    sirq_route_matrix u_sirq_route_matrix (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .src_req(src_req), .irq_out(irq_out)
    );

    typedef struct {
        logic [7:0]  out;
        logic [31:0] rd;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   n_vec = 0;
    int   n_bad = 0;
    logic [SRC_N-1:0] cur_src = '0;

    // Model state, from the register description
    logic [7:0] m_en = '0, m_lvl = '0, m_prev = '0;
    logic [3:0] m_dst [SRC_N];

    function automatic logic [7:0] m_merge(input logic [SRC_N-1:0] s);
        logic [7:0] r = '0;
        logic [SRC_N-1:0] on;
        on = {4'b1111, m_en[2], m_en[0], m_en[5], m_en[3], m_en[1]};
        for (int k = 0; k < SRC_N; k++)
            if (s[k] && on[k] && m_dst[k] != 0 && m_dst[k] < 8)
                r[m_dst[k][2:0]] = 1'b1;
        return r;
    endfunction

    function automatic logic [31:0] m_read(input logic [7:0] a);
        logic [31:0] r = '0;
        case (a)
            8'h58: r[23:16] = m_en;
            8'h64: r[31:24] = m_lvl;
            8'h68: r = {4'h0, m_dst[4], m_dst[3], m_dst[2], m_dst[1], m_dst[0], 8'h00};
            8'h6C: r = {16'h0, m_dst[8], m_dst[7], m_dst[6], m_dst[5]};
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic step(input logic we, input logic [7:0] a,
                        input logic [31:0] d, input string tag);
        exp_t       e;
        logic [7:0] mg;
        @(negedge clk);
        cfg_we = we; cfg_addr = a; cfg_wdata = d; src_req = cur_src;
        mg    = m_merge(cur_src);
        e.out = (m_lvl & mg) | (~m_lvl & mg & ~m_prev);
        m_prev = mg;
        if (we) begin
            case (a)
                8'h58: m_en  = d[23:16];
                8'h64: m_lvl = d[31:24];
                8'h68: begin
                    m_dst[0] = d[11:8];  m_dst[1] = d[15:12];
                    m_dst[2] = d[19:16]; m_dst[3] = d[23:20];
                    m_dst[4] = d[27:24];
                end
                8'h6C: begin
                    m_dst[5] = d[3:0];  m_dst[6] = d[7:4];
                    m_dst[7] = d[11:8]; m_dst[8] = d[15:12];
                end
                default: ;
            endcase
        end
        e.rd  = m_read(a);
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
        step(1'b1, a, d, tag);
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        step(1'b0, a, '0, tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 8'h68, '0, tag);
    endtask

    // Monitor: pop and compare after each active edge
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                e = q.pop_front();
                n_vec++;
                if (irq_out !== e.out) begin
                    n_bad++;
                    $display("FAIL %s irq_out: actual %h expected %h", e.tag, irq_out, e.out);
                end
                if (cfg_rdata !== e.rd) begin
                    n_bad++;
                    $display("FAIL %s cfg_rdata: actual %h expected %h", e.tag, cfg_rdata, e.rd);
                end
            end
        end
    end

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        for (int k = 0; k < SRC_N; k++) m_dst[k] = '0;
        rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; src_req = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state, all sources asserted reach nothing
        cur_src = '1;
        rd(8'h58, "R1 enable"); rd(8'h64, "R1 trig");
        rd(8'h68, "R1 map_a");  rd(8'h6C, "R1 map_b");
        cur_src = '0;
        idle(1, "R1 idle");

        // Program the standard layout; R3 reserved nibble, R10 empty lanes
        wr(8'h68, 32'hF765_4300, "R2 R3 map_a write");
        rd(8'h68, "R3 R10 map_a readback");
        wr(8'h64, 32'h82AA_55AA, "R8 R10 trig write");
        wr(8'h6C, 32'hFFFF_1000, "R4 R10 map_b write");
        wr(8'h58, 32'hFF2F_FFFF, "R6 R10 enable write");
        rd(8'h40, "R10 unmapped offset");

        // Single sources: R2 serial, R3 parallel/floppy/IDE, R9 edge held
        cur_src = 9'h001; idle(3, "R2 R9 ser1 line3 held");
        cur_src = 9'h000; idle(1, "R9 release");
        cur_src = 9'h002; idle(2, "R2 ser2 line4");
        cur_src = 9'h004; idle(2, "R3 par line5");
        cur_src = 9'h008; idle(2, "R3 fdc line6");
        cur_src = 9'h010; idle(3, "R3 R8 ide1 line7 level");
        cur_src = 9'h000; idle(2, "R8 level release");
        cur_src = 9'h100; idle(3, "R4 R8 intd line1 level");
        cur_src = 9'h000; idle(2, "R8 release");

        // R4: all four PCI wires
        wr(8'h6C, 32'h0000_4321, "R4 pci map");
        cur_src = 9'h020; idle(2, "R4 inta line1");
        cur_src = 9'h040; idle(2, "R4 intb line2");
        cur_src = 9'h080; idle(2, "R4 intc line3");
        cur_src = 9'h100; idle(2, "R4 intd line4");
        cur_src = 9'h000; idle(1, "R4 idle");
        wr(8'h6C, 32'h0000_1000, "R4 restore");

        // R6: enables
        wr(8'h58, 32'h0000_0000, "R6 disable all");
        cur_src = 9'h01F; idle(3, "R6 disabled sources ignored");
        cur_src = 9'h11F; idle(2, "R6 pci still routed");
        wr(8'h58, 32'h0020_0000, "R6 enable parallel only");
        idle(2, "R6 parallel after enable");
        cur_src = 9'h000; idle(2, "R6 idle");
        wr(8'h58, 32'h002F_0000, "R6 enable all");

        // R7: two serial ports sharing line 3
        wr(8'h68, 32'h0765_3300, "R7 share line3");
        cur_src = 9'h001; idle(2, "R7 ser1 alone edge");
        cur_src = 9'h003; idle(2, "R7 both, no second edge");
        cur_src = 9'h002; idle(1, "R7 ser2 holds");
        cur_src = 9'h000; idle(1, "R7 release");
        cur_src = 9'h002; idle(1, "R7 ser2 new edge");
        cur_src = 9'h000; idle(1, "R7 release");
        wr(8'h64, 32'h8A00_0000, "R7 R8 line3 level");
        cur_src = 9'h001; idle(1, "R7 level ser1");
        cur_src = 9'h003; idle(1, "R7 level both");
        cur_src = 9'h002; idle(1, "R7 level ser2 keeps high");
        cur_src = 9'h000; idle(2, "R7 level release");

        // R5: out-of-range and zero fields
        wr(8'h68, 32'h0765_9F00, "R5 fields 15 and 9");
        cur_src = 9'h003; idle(3, "R5 out of range nowhere");
        cur_src = 9'h000;
        wr(8'h68, 32'h0000_0000, "R5 all zero");
        wr(8'h6C, 32'h0000_0000, "R5 pci zero");
        cur_src = 9'h1FF; idle(2, "R5 unrouted");
        cur_src = 9'h000;

        // R9: toggling request on an edge line
        wr(8'h68, 32'h0765_4300, "R9 restore map");
        wr(8'h64, 32'h8200_0000, "R9 restore trig");
        for (int i = 0; i < 4; i++) begin
            cur_src = 9'h001; idle(1, "R9 toggle high");
            cur_src = 9'h000; idle(1, "R9 toggle low");
        end

        @(negedge clk);
        cfg_we = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule